// File: doc/BRIEF.md
# Branch Target Generator

This block turns a branch request into a 24-bit even target address for a 16-bit processor with a 24-bit program counter. A request is taken on a `start` strobe. It is then handled in one of two ways. In relative form, a signed 8-bit or 16-bit offset is added to the address of the instruction that follows the branch, and the result is ready one cycle later. In indirect form, an 8-bit absolute pointer names a vector slot in the lowest 256 bytes of memory. The block reads the target from that slot through a 16-bit big-endian read port that has a ready handshake.

The `adv_mode` input selects the vector format. With `adv_mode` low, the vector is one 16-bit word. With `adv_mode` high, it is a 32-bit longword whose most significant byte is discarded. Every result has its lowest bit cleared. `odd_target` reports whether that bit was set before it was cleared. A single-cycle `done` pulse marks each new result.

Top module: `bta_gen`

## Requirements
- R1: With `ind_mode`=0 and `disp_wide`=0, `target` is the low 24 bits of `next_pc` plus `disp[7:0]` sign-extended to 24 bits. `disp[15:8]` has no effect on the result.
- R2: With `ind_mode`=0 and `disp_wide`=1, all 16 bits of `disp` are sign-extended to 24 bits and added to `next_pc`.
- R3: The relative sum wraps modulo 2^24. A carry out of bit 23 is discarded, and so is a borrow below zero.
- R4: A relative request that is accepted while the block is idle raises `done` on the clock edge right after the one that sampled `start`.
- R5: An indirect request (`ind_mode`=1) drives `mem_addr` with `abs_addr` zero-extended to 24 bits and its bit 0 cleared. `mem_req` is raised for this read. `mem_req` and `mem_addr` stay unchanged until a cycle in which `mem_ready` is high, and that cycle completes the read.
- R6: With `adv_mode`=0, an indirect request makes exactly one read. `target` is the returned 16-bit word zero-extended to 24 bits. `done` rises one cycle after the completing handshake.
- R7: With `adv_mode`=1, an indirect request makes exactly two reads, the first at the vector address and the second at that address plus 2. `target[23:16]` is `mem_rdata[7:0]` of the first read, and `target[15:0]` is the second word. `mem_rdata[15:8]` of the first read has no effect.
- R8: `target[0]` is always 0 when `done` is high. `odd_target` equals bit 0 of the result before that bit was cleared.
- R9: `done` is high for exactly one cycle per request. `target` and `odd_target` hold their values between `done` pulses.
- R10: `busy` is high while an indirect fetch is in progress. A `start` seen while `busy` is high is ignored: it produces no `done` and does not change the result that is pending.
- R11: During reset and after it, `done`, `target`, `odd_target`, `mem_req` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| ind_mode | input | 1 | 0 = relative offset, 1 = indirect vector |
| adv_mode | input | 1 | 0 = 16-bit vector, 1 = 32-bit vector with top byte dropped |
| disp_wide | input | 1 | 0 = 8-bit offset, 1 = 16-bit offset |
| disp | input | 16 | Signed offset |
| next_pc | input | 24 | Address of the instruction after the branch |
| abs_addr | input | 8 | Vector slot pointer |
| mem_req | output | 1 | Read request |
| mem_addr | output | 24 | Read byte address (always even) |
| mem_rdata | input | 16 | Read word, big-endian |
| mem_ready | input | 1 | Read completes this cycle |
| target | output | 24 | Even branch target |
| done | output | 1 | One-cycle result strobe |
| odd_target | output | 1 | Result had bit 0 set before clearing |
| busy | output | 1 | Indirect fetch in progress |

## Verification
The bench targets the following corner cases:
- Offsets of -128, +127, -32768 and +32767. A design that zero-extends the offset or takes it from the wrong width lands thousands of bytes off.
- A PC near the top of the address space with a positive offset, and a PC near zero with a negative offset. These show whether the sum wraps or spills into a 25th bit.
- Odd raw targets and odd vector pointers. These show whether bit 0 is cleared on both the vector address and the result, and whether `odd_target` tracks the bit as it was before clearing.
- A vector at 0xFE in the 32-bit format, whose second read crosses to 0x100. The bench also changes the response latency and sends a `start` in the middle of a fetch. A design that drops the request, re-reads, mixes up the word order or accepts the extra start gives a wrong read count, a wrong cycle count or a second `done`.

// File: rtl/bta_pkg.sv
package bta_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_HI   = 2'd1,
        FS_LO   = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/bta_rel_calc.sv
module bta_rel_calc #(
    parameter int PC_W    = 24,
    parameter int DISP_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic [PC_W-1:0]   next_pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              wide,
    output logic [PC_W-1:0]   sum_raw
);
    localparam int LONG_PAD  = PC_W - DISP_W;
    localparam int SHORT_PAD = PC_W - SHORT_W;

    logic [PC_W-1:0] ext_long;
    logic [PC_W-1:0] ext_short;
    logic [PC_W-1:0] ext_sel;

    always_comb begin
        ext_long  = {{LONG_PAD{disp[DISP_W-1]}}, disp};
        ext_short = {{SHORT_PAD{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        ext_sel   = wide ? ext_long : ext_short;
        // Carry beyond the top bit is dropped by the width of the sum.
        sum_raw   = next_pc + ext_sel;
    end
endmodule

// File: rtl/bta_vec_fetch.sv
module bta_vec_fetch
    import bta_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              adv,
    input  logic [VEC_W-1:0]  vec_ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              fin,
    output logic [ADDR_W-1:0] raw,
    output logic              busy
);
    localparam int HI_W    = ADDR_W - WORD_W;
    localparam int PTR_PAD = ADDR_W - VEC_W;
    localparam int STEP    = WORD_W / 8;

    typedef struct packed {
        fetch_st_e        st;
        logic             adv;
        logic [ADDR_W-1:0] addr;
        logic [HI_W-1:0]  hi;
    } fetch_s;

    fetch_s q, d;

    always_comb begin
        d   = q;
        fin = 1'b0;
        raw = '0;
        unique case (q.st)
            FS_IDLE: begin
                if (go) begin
                    d.st   = FS_HI;
                    d.adv  = adv;
                    d.addr = {{PTR_PAD{1'b0}}, vec_ptr} & ~ADDR_W'(1);
                end
            end
            FS_HI: begin
                if (mem_ready) begin
                    if (q.adv) begin
                        d.hi   = mem_rdata[HI_W-1:0];
                        d.addr = q.addr + ADDR_W'(STEP);
                        d.st   = FS_LO;
                    end else begin
                        fin  = 1'b1;
                        raw  = {{HI_W{1'b0}}, mem_rdata};
                        d.st = FS_IDLE;
                    end
                end
            end
            FS_LO: begin
                if (mem_ready) begin
                    fin  = 1'b1;
                    raw  = {q.hi, mem_rdata};
                    d.st = FS_IDLE;
                end
            end
            default: d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: FS_IDLE, adv: 1'b0, addr: '0, hi: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_req  = (q.st != FS_IDLE);
    assign busy     = (q.st != FS_IDLE);
    assign mem_addr = q.addr;

    // R5: an outstanding read keeps its request and address until ready
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R5: the vector read stays inside the low page plus one word
    assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr < ADDR_W'((1 << VEC_W) + STEP)));

    // R7: the second read of a long vector is one word above the first
    assert_second_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == FS_HI && mem_ready && q.adv) |=>
            (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(STEP)));
endmodule

// File: rtl/bta_gen.sv
module bta_gen
    import bta_pkg::*;
#(
    parameter int PC_W    = 24,
    parameter int DISP_W  = 16,
    parameter int SHORT_W = 8,
    parameter int WORD_W  = 16,
    parameter int VEC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ind_mode,
    input  logic              adv_mode,
    input  logic              disp_wide,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   next_pc,
    input  logic [VEC_W-1:0]  abs_addr,
    output logic              mem_req,
    output logic [PC_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [PC_W-1:0]   target,
    output logic              done,
    output logic              odd_target,
    output logic              busy
);
    typedef struct packed {
        logic            done;
        logic [PC_W-1:0] target;
        logic            odd;
    } out_s;

    out_s q, d;

    logic [PC_W-1:0] rel_sum;
    logic [PC_W-1:0] fetch_raw;
    logic            fetch_fin;
    logic            fetch_busy;
    logic            fetch_go;
    logic            rel_go;

    bta_rel_calc #(
        .PC_W    (PC_W),
        .DISP_W  (DISP_W),
        .SHORT_W (SHORT_W)
    ) rel_i (
        .next_pc (next_pc),
        .disp    (disp),
        .wide    (disp_wide),
        .sum_raw (rel_sum)
    );

    bta_vec_fetch #(
        .ADDR_W (PC_W),
        .WORD_W (WORD_W),
        .VEC_W  (VEC_W)
    ) fetch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (fetch_go),
        .adv       (adv_mode),
        .vec_ptr   (abs_addr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .fin       (fetch_fin),
        .raw       (fetch_raw),
        .busy      (fetch_busy)
    );

    assign fetch_go = start && ind_mode && !fetch_busy;
    assign rel_go   = start && !ind_mode && !fetch_busy;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        if (fetch_fin) begin
            d.done   = 1'b1;
            d.target = fetch_raw & ~PC_W'(1);
            d.odd    = fetch_raw[0];
        end else if (rel_go) begin
            d.done   = 1'b1;
            d.target = rel_sum & ~PC_W'(1);
            d.odd    = rel_sum[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{done: 1'b0, target: '0, odd: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done       = q.done;
    assign target     = q.target;
    assign odd_target = q.odd;
    assign busy       = fetch_busy;

    // R4: an idle relative request finishes on the next edge
    assert_rel_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ind_mode && !busy) |=> done);

    // R10: a result never appears while a fetch is still open
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: the result registers only move together with a done pulse
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(target) && $stable(odd_target)));

    // R8: the reported target is even whenever it is announced
    assert_even_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (target[0] == 1'b0));
endmodule

// File: tb/bta_gen_tb_top.sv
`timescale 1ns/1ps
module bta_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        ind_mode;
    logic        adv_mode;
    logic        disp_wide;
    logic [15:0] disp;
    logic [23:0] next_pc;
    logic [7:0]  abs_addr;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        mem_ready;
    logic [23:0] target;
    logic        done;
    logic        odd_target;
    logic        busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bta_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ind_mode(ind_mode),
        .adv_mode(adv_mode), .disp_wide(disp_wide), .disp(disp),
        .next_pc(next_pc), .abs_addr(abs_addr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .target(target), .done(done), .odd_target(odd_target), .busy(busy)
    );

    // Memory model: word at byte address a is {a+0x11, a^0x3C^a[2]}
    function automatic logic [15:0] mem_word(input logic [23:0] a);
        return {a[7:0] + 8'h11, a[7:0] ^ 8'h3C ^ {7'b0, a[2]}};
    endfunction

    logic [7:0]  lat;
    logic [7:0]  wait_cnt;
    logic        log_clr;
    int          rd_count;
    logic [23:0] rd_addr [4];

    assign mem_ready = mem_req && (wait_cnt >= lat);
    assign mem_rdata = mem_req ? mem_word(mem_addr) : 16'h0000;

    always @(posedge clk) begin
        if (!rst_n || !mem_req || mem_ready) wait_cnt <= 8'd0;
        else wait_cnt <= wait_cnt + 8'd1;
    end

    always @(posedge clk) begin
        if (log_clr) rd_count <= 0;
        else if (mem_req && mem_ready) begin
            if (rd_count < 4) rd_addr[rd_count] <= mem_addr;
            rd_count <= rd_count + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        ind;
        logic        adv;
        logic        wide;
        logic [15:0] dsp;
        logic [23:0] pc;
        logic [7:0]  ptr;
        logic [23:0] exp_t;
        logic        exp_o;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 16'h0080, 24'h001000, 8'h00, 24'h000F80, 1'b0}, // R1 -128
        '{1'b0, 1'b0, 1'b0, 16'h007F, 24'h001000, 8'h00, 24'h00107E, 1'b1}, // R1 R8 +127
        '{1'b0, 1'b0, 1'b1, 16'h0020, 24'hFFFFF0, 8'h00, 24'h000010, 1'b0}, // R3 wrap up
        '{1'b0, 1'b0, 1'b1, 16'h8000, 24'h000010, 8'h00, 24'hFF8010, 1'b0}, // R2 R3 -32768
        '{1'b0, 1'b0, 1'b0, 16'hAB05, 24'h123456, 8'h00, 24'h12345A, 1'b1}, // R1 upper byte ignored
        '{1'b0, 1'b0, 1'b1, 16'h7FFF, 24'h000002, 8'h00, 24'h008000, 1'b1}, // R2 +32767
        '{1'b1, 1'b0, 1'b0, 16'h0000, 24'h000000, 8'h40, 24'h00517C, 1'b0}, // R6
        '{1'b1, 1'b0, 1'b0, 16'h0000, 24'h000000, 8'h45, 24'h005578, 1'b1}, // R5 odd ptr, R8
        '{1'b1, 1'b1, 1'b0, 16'h0000, 24'h000000, 8'h40, 24'h7C537E, 1'b0}, // R7
        '{1'b1, 1'b1, 1'b0, 16'h0000, 24'h000000, 8'hFE, 24'hC3113C, 1'b0}, // R7 crosses 0x100
        '{1'b1, 1'b1, 1'b0, 16'h0000, 24'h000000, 8'h0C, 24'h311F32, 1'b1}  // R7 R8
    };

    task automatic run_vec(input vec_t v);
        int cycles;
        logic [23:0] base;
        int exp_cyc;
        @(negedge clk);
        ind_mode  = v.ind;
        adv_mode  = v.adv;
        disp_wide = v.wide;
        disp      = v.dsp;
        next_pc   = v.pc;
        abs_addr  = v.ptr;
        start     = 1'b1;
        log_clr   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        log_clr = 1'b0;
        cycles  = 1;
        while (!done && cycles < 60) begin
            @(negedge clk);
            cycles++;
        end
        check(done == 1'b1, "R9 done seen", 32'(done), 32'd1);
        check(target == v.exp_t, v.ind ? (v.adv ? "R7 target" : "R6 target") :
              (v.wide ? "R2 R3 target" : "R1 R3 target"), 32'(target), 32'(v.exp_t));
        check(odd_target == v.exp_o, "R8 odd_target", 32'(odd_target), 32'(v.exp_o));
        if (!v.ind) begin
            check(cycles == 1, "R4 relative latency", 32'(cycles), 32'd1);
        end else begin
            base    = {16'h0000, v.ptr[7:1], 1'b0};
            exp_cyc = (v.adv ? 2 : 1) * (int'(lat) + 1) + 1;
            check(cycles == exp_cyc, "R5 fetch latency", 32'(cycles), 32'(exp_cyc));
            check(rd_count == (v.adv ? 2 : 1), v.adv ? "R7 read count" : "R6 read count",
                  32'(rd_count), v.adv ? 32'd2 : 32'd1);
            check(rd_addr[0] == base, "R5 vector address", 32'(rd_addr[0]), 32'(base));
            if (v.adv)
                check(rd_addr[1] == base + 24'd2, "R7 second address",
                      32'(rd_addr[1]), 32'(base + 24'd2));
        end
        @(negedge clk);
        check(done == 1'b0, "R9 single pulse", 32'(done), 32'd0);
        check(target == v.exp_t, "R9 target held", 32'(target), 32'(v.exp_t));
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; ind_mode = 1'b0; adv_mode = 1'b0;
        disp_wide = 1'b0; disp = '0; next_pc = '0; abs_addr = '0;
        lat = 8'd0; log_clr = 1'b1;
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R11 done in reset", 32'(done), 32'd0);
        check(target == 24'd0, "R11 target in reset", 32'(target), 32'd0);
        check(odd_target == 1'b0, "R11 odd in reset", 32'(odd_target), 32'd0);
        check(mem_req == 1'b0, "R11 mem_req in reset", 32'(mem_req), 32'd0);
        check(busy == 1'b0, "R11 busy in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        check(done == 1'b0 && mem_req == 1'b0, "R11 idle after reset",
              {30'd0, done, mem_req}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R5 R7: slow memory, request must wait
        lat = 8'd3;
        run_vec(VECS[10]);
        run_vec(VECS[7]);

        // R10: start during a fetch is ignored
        begin
            int dones;
            lat = 8'd2;
            @(negedge clk);
            ind_mode = 1'b1; adv_mode = 1'b0; abs_addr = 8'h40;
            start = 1'b1; log_clr = 1'b1;
            @(negedge clk);
            log_clr = 1'b0;
            check(busy == 1'b1, "R10 busy during fetch", 32'(busy), 32'd1);
            ind_mode = 1'b0; disp_wide = 1'b0; disp = 16'h0004; next_pc = 24'h000100;
            dones = 0;
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 10; c++) begin
                if (done) begin
                    dones++;
                    check(target == 24'h00517C, "R10 pending result kept",
                          32'(target), 32'h00517C);
                end
                @(negedge clk);
            end
            check(dones == 1, "R10 one done only", 32'(dones), 32'd1);
            check(rd_count == 1, "R10 no extra read", 32'(rd_count), 32'd1);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule